// File: doc/BRIEF.md
# Time-over-Threshold Event Sequencer with Dark-Count Rejection

This block is the clocked controller for one photodetector readout channel. It watches a synchronized low-threshold hit flag. When a hit arrives while the channel is idle, it raises a time-over-threshold (ToT) output and starts timing two windows: a short validation window and a long integration window. When the short window ends, the block checks the charge comparator flag. A charge below threshold means the event is a dark count. In that case the whole channel is cleared at once, so the ToT pulse lasts exactly the short window.

When the charge is above threshold, integration goes on until the long window ends. The block then enables a constant-current discharge of integrator B. The ToT pulse ends when the discharge-done comparator rises, so its width grows with the collected charge. A timeout guards against a discharge-done flag that never arrives. Every finished event produces a one-cycle report that gives the class (dark or valid) and the ToT length in clock cycles.

The charge threshold and the discharge current code are held in configuration registers and driven straight to the analog side. The analog integrators, comparators and current sources are outside this block; they appear here only as input flags.

Top module: `tot_dark_reject_seq`

## Requirements
- R1: While reset is asserted and right after it, `tot_o`, `rst_a_o`, `rst_b_o`, `dchg_en_o`, `evt_stb_o` and `err_o` are 0, and the configuration outputs `thr_o` and `dchg_o` are 0.
- R2: A rising edge of `hit_i` seen while idle makes `tot_o` high from the next cycle. A rising edge of `hit_i` seen while an event is in progress changes neither the timing nor the result of that event.
- R3: If `chg_i` is 0 in the last cycle of window A, the event is dark. `tot_o` has then been high for exactly LA = max(win_a,1)·TICK_CYC cycles. In the next cycle `tot_o` is 0 and both `rst_a_o` and `rst_b_o` are 1.
- R4: If `chg_i` is 1 at the end of window A, `dchg_en_o` first rises after `tot_o` has been high for max(LA, LB) cycles, where LB = max(win_b,1)·4·TICK_CYC. `dchg_en_o` is only ever high while `tot_o` is high.
- R5: A rising edge of `done_i` while `dchg_en_o` is high ends the event. In the next cycle `tot_o` and `dchg_en_o` are 0, `rst_b_o` is 1 and `rst_a_o` is 0.
- R6: A window setting of 0 behaves as a setting of 1. Window A is then TICK_CYC cycles long and window B is 4·TICK_CYC cycles long.
- R7: If `done_i` does not rise within TIMEOUT discharge cycles, the event ends as a valid event after exactly TIMEOUT discharge cycles, and `err_o` is set. `err_o` then stays 1 until a cycle with `cfg_we_i` high, after which it reads 0.
- R8: Each finished event gives exactly one cycle of `evt_stb_o`. This is the first cycle of the reset phase. In that cycle `evt_dark_o` gives the class (1 = dark) and `evt_len_o` gives the number of cycles `tot_o` was high, saturating at all ones.
- R9: When `cfg_we_i` is high at a clock edge, the window settings, `thr_o` and `dchg_o` take the presented values from the next cycle.
- R10: The reset phase lasts exactly 2 cycles, after which the block is idle. A `hit_i` level that stays high into the idle state does not start a new event; a new rising edge is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | 1 | Synchronized low-threshold hit flag |
| chg_i | input | 1 | Synchronized charge-above-threshold flag (integrator A) |
| done_i | input | 1 | Synchronized discharge-done flag (integrator B back at baseline) |
| cfg_we_i | input | 1 | Configuration write strobe; also clears the error flag |
| cfg_win_a_i | input | WIN_W | Window A setting in base ticks |
| cfg_win_b_i | input | WIN_W | Window B setting in units of four base ticks |
| cfg_thr_i | input | THR_W | Charge threshold code |
| cfg_dchg_i | input | DCHG_W | Discharge current code |
| tot_o | output | 1 | Time-over-threshold pulse |
| rst_a_o | output | 1 | Integrator A reset (dark events) |
| rst_b_o | output | 1 | Integrator B reset (every event end) |
| dchg_en_o | output | 1 | Constant-current discharge enable |
| thr_o | output | THR_W | Registered charge threshold to the analog side |
| dchg_o | output | DCHG_W | Registered discharge current code to the analog side |
| evt_stb_o | output | 1 | One-cycle event completion strobe |
| evt_dark_o | output | 1 | Event class, valid with the strobe: 1 = dark |
| evt_len_o | output | CNT_W | ToT length in cycles, valid with the strobe |
| err_o | output | 1 | Sticky discharge timeout flag |

## Verification
The assertions assume three things about the inputs. The flags are already synchronized to `clk`. The configuration is not rewritten while an event is in progress. And `done_i` rises no more than once per discharge phase. The stimulus keeps to this: all inputs change on the falling clock edge, writes happen only after the reset phase has finished and the block is idle, and `done_i` is raised once during discharge and lowered only after `tot_o` has fallen. Stray hits are placed inside events on purpose, and in one case a hit is held high into the idle state, to show that only a fresh edge from idle starts an event.

// File: rtl/tot_seq_pkg.sv
package tot_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WIN_A,
    ST_WIN_B,
    ST_DCHG,
    ST_RST
  } seq_state_e;

  // number of cycles the end-of-event reset phase lasts
  localparam int unsigned RST_CYC = 2;
  // window B step expressed in window A steps
  localparam int unsigned B_PER_A = 4;

  // window length in clock cycles: a zero setting counts as one step
  function automatic int unsigned win_cycles(input int unsigned setting,
                                             input int unsigned step_cyc);
    int unsigned s;
    s = (setting == 0) ? 1 : setting;
    return s * step_cyc;
  endfunction

endpackage

// File: rtl/tot_rise_det.sv
module tot_rise_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] lvl_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q[i] <= 1'b0;
      else        lvl_q[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~lvl_q[i];
  end

endmodule

// File: rtl/tot_cycle_counter.sv
module tot_cycle_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (start)              cnt <= W'(1);
    else if (clr)                cnt <= '0;
    else if (inc && cnt != '1)   cnt <= cnt + 1'b1;
  end

  // R8
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !clr && inc && cnt == '1) |=> (cnt == '1));

endmodule

// File: rtl/tot_seq_fsm.sv
module tot_seq_fsm
  import tot_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_rise,
  input  logic             done_rise,
  input  logic             chg_i,
  input  logic [CNT_W-1:0] len_a,
  input  logic [CNT_W-1:0] len_b,
  input  logic [CNT_W-1:0] ecnt,
  input  logic             tmo_last,
  output seq_state_e       state_o,
  output logic             tot_o,
  output logic             rst_a_o,
  output logic             rst_b_o,
  output logic             dchg_en_o,
  output logic             tmo_o,
  output logic             evt_stb_o,
  output logic             evt_dark_o,
  output logic [CNT_W-1:0] evt_len_o
);
  seq_state_e       state, nxt;
  logic             dark_q, dark_nxt, go_rst;
  logic [1:0]       rcnt;
  logic             stb_q;
  logic [CNT_W-1:0] len_q;
  logic             win_a_end, win_b_end;

  assign win_a_end = (ecnt >= len_a);
  assign win_b_end = (ecnt >= len_b);

  always_comb begin
    nxt      = state;
    dark_nxt = dark_q;
    tmo_o    = 1'b0;
    unique case (state)
      ST_IDLE:  if (hit_rise) nxt = ST_WIN_A;
      ST_WIN_A: if (win_a_end) begin
                  if (!chg_i) begin
                    nxt = ST_RST; dark_nxt = 1'b1;
                  end else begin
                    nxt = win_b_end ? ST_DCHG : ST_WIN_B;
                  end
                end
      ST_WIN_B: if (win_b_end) nxt = ST_DCHG;
      ST_DCHG:  if (done_rise) begin
                  nxt = ST_RST; dark_nxt = 1'b0;
                end else if (tmo_last) begin
                  nxt = ST_RST; dark_nxt = 1'b0; tmo_o = 1'b1;
                end
      ST_RST:   if (rcnt == 2'(RST_CYC - 1)) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  assign go_rst = (nxt == ST_RST) && (state != ST_RST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      dark_q <= 1'b0;
      rcnt   <= '0;
      stb_q  <= 1'b0;
      len_q  <= '0;
    end else begin
      state <= nxt;
      stb_q <= go_rst;
      if (go_rst) begin
        dark_q <= dark_nxt;
        len_q  <= ecnt;
        rcnt   <= '0;
      end else if (state == ST_RST) begin
        rcnt <= rcnt + 1'b1;
      end
    end
  end

  assign state_o    = state;
  assign tot_o      = (state == ST_WIN_A) || (state == ST_WIN_B) || (state == ST_DCHG);
  assign dchg_en_o  = (state == ST_DCHG);
  assign rst_b_o    = (state == ST_RST);
  assign rst_a_o    = (state == ST_RST) && dark_q;
  assign evt_stb_o  = stb_q;
  assign evt_dark_o = dark_q;
  assign evt_len_o  = len_q;

  // R2
  tot_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && hit_rise) |=> tot_o);
  // R3
  dark_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WIN_A && win_a_end && !chg_i) |=> (rst_a_o && rst_b_o && !tot_o));
  // R4
  dchg_in_tot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dchg_en_o |-> tot_o);
  // R5
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dchg_en_o && done_rise) |=> (rst_b_o && !rst_a_o && !tot_o && !dchg_en_o));
  // R8
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stb_o |=> !evt_stb_o);
  // R8
  stb_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stb_o |-> (rst_b_o && !tot_o));
  // R10
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_b_o) |=> rst_b_o);
  // R10
  rst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_b_o && $past(rst_b_o)) |=> (!rst_b_o && !tot_o));

endmodule

// File: rtl/tot_dark_reject_seq.sv
module tot_dark_reject_seq
  import tot_seq_pkg::*;
#(
  parameter int WIN_W    = 8,
  parameter int THR_W    = 8,
  parameter int DCHG_W   = 4,
  parameter int CNT_W    = 16,
  parameter int TICK_CYC = 1,
  parameter int TIMEOUT  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_i,
  input  logic              chg_i,
  input  logic              done_i,
  input  logic              cfg_we_i,
  input  logic [WIN_W-1:0]  cfg_win_a_i,
  input  logic [WIN_W-1:0]  cfg_win_b_i,
  input  logic [THR_W-1:0]  cfg_thr_i,
  input  logic [DCHG_W-1:0] cfg_dchg_i,
  output logic              tot_o,
  output logic              rst_a_o,
  output logic              rst_b_o,
  output logic              dchg_en_o,
  output logic [THR_W-1:0]  thr_o,
  output logic [DCHG_W-1:0] dchg_o,
  output logic              evt_stb_o,
  output logic              evt_dark_o,
  output logic [CNT_W-1:0]  evt_len_o,
  output logic              err_o
);
  localparam int TMO_W = $clog2(TIMEOUT) + 1;

  logic [WIN_W-1:0] win_a_q, win_b_q;
  logic [CNT_W-1:0] len_a, len_b, ecnt;
  logic [TMO_W-1:0] tcnt;
  logic [1:0]       rise;
  logic             hit_rise, done_rise, tmo_last, tmo_evt, err_q;
  seq_state_e       state;

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_a_q <= '0;
      win_b_q <= '0;
      thr_o   <= '0;
      dchg_o  <= '0;
    end else if (cfg_we_i) begin
      win_a_q <= cfg_win_a_i;
      win_b_q <= cfg_win_b_i;
      thr_o   <= cfg_thr_i;
      dchg_o  <= cfg_dchg_i;
    end
  end

  assign len_a = CNT_W'(win_cycles(32'(win_a_q), TICK_CYC));
  assign len_b = CNT_W'(win_cycles(32'(win_b_q), B_PER_A * TICK_CYC));

  tot_rise_det #(.N(2)) u_rise (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  ({done_i, hit_i}),
    .rise (rise)
  );
  assign hit_rise  = rise[0];
  assign done_rise = rise[1];

  // cycles since the ToT pulse began; doubles as the event length
  tot_cycle_counter #(.W(CNT_W)) u_elapsed (
    .clk  (clk),
    .rst_n(rst_n),
    .start(state == ST_IDLE && hit_rise),
    .clr  (!tot_o),
    .inc  (tot_o),
    .cnt  (ecnt)
  );

  // discharge phase duration, for the missing-done guard
  tot_cycle_counter #(.W(TMO_W)) u_tmo (
    .clk  (clk),
    .rst_n(rst_n),
    .start(1'b0),
    .clr  (state != ST_DCHG),
    .inc  (state == ST_DCHG),
    .cnt  (tcnt)
  );
  assign tmo_last = (tcnt == TMO_W'(TIMEOUT - 1));

  tot_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_rise  (hit_rise),
    .done_rise (done_rise),
    .chg_i     (chg_i),
    .len_a     (len_a),
    .len_b     (len_b),
    .ecnt      (ecnt),
    .tmo_last  (tmo_last),
    .state_o   (state),
    .tot_o     (tot_o),
    .rst_a_o   (rst_a_o),
    .rst_b_o   (rst_b_o),
    .dchg_en_o (dchg_en_o),
    .tmo_o     (tmo_evt),
    .evt_stb_o (evt_stb_o),
    .evt_dark_o(evt_dark_o),
    .evt_len_o (evt_len_o)
  );

  // sticky timeout flag; a new timeout wins over a clearing write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        err_q <= 1'b0;
    else if (tmo_evt)  err_q <= 1'b1;
    else if (cfg_we_i) err_q <= 1'b0;
  end
  assign err_o = err_q;

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !cfg_we_i) |=> err_o);
  // R7
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> (rst_b_o && !rst_a_o));
  // R9
  cfg_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we_i |=> (thr_o == $past(cfg_thr_i) && dchg_o == $past(cfg_dchg_i)));

endmodule

// File: tb/sim_tot_dark_reject_seq.sv
module sim_tot_dark_reject_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TICK = 2;
  localparam int TMO  = 1024;

  typedef struct {
    bit dark;
    int len;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hit = 1'b0, chg = 1'b0, done = 1'b0, we = 1'b0;
  logic [7:0] wa = '0, wb = '0, thr = '0;
  logic [3:0] dc = '0;
  logic tot, rsta, rstb, dchg_en, stb, dark, err;
  logic [7:0] thr_o;
  logic [3:0] dchg_o;
  logic [15:0] len_o;

  item_t sb_q[$];
  int checks = 0, fails = 0, pushed = 0, stb_seen = 0;
  int exp_la = TICK, exp_lb = 4 * TICK;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tot_dark_reject_seq #(.TICK_CYC(TICK), .TIMEOUT(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .chg_i(chg), .done_i(done),
    .cfg_we_i(we), .cfg_win_a_i(wa), .cfg_win_b_i(wb), .cfg_thr_i(thr),
    .cfg_dchg_i(dc), .tot_o(tot), .rst_a_o(rsta), .rst_b_o(rstb),
    .dchg_en_o(dchg_en), .thr_o(thr_o), .dchg_o(dchg_o), .evt_stb_o(stb),
    .evt_dark_o(dark), .evt_len_o(len_o), .err_o(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int steps(input int s);
    return (s == 0) ? 1 : s;
  endfunction

  task automatic cfg(input int a, input int b, input int t, input int d);
    @(negedge clk);
    wa = 8'(a); wb = 8'(b); thr = 8'(t); dc = 4'(d); we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    exp_la = steps(a) * TICK;
    exp_lb = steps(b) * 4 * TICK;
    chk("R9 thr", int'(thr_o), t);
    chk("R9 dchg", int'(dchg_o), d);
  endtask

  // driver: plays one event and pushes the expected report
  task automatic run_event(input string tag, input bit is_dark, input int d,
                           input bit tmo, input bit repulse);
    item_t it;
    int pre, exp_pre;
    exp_pre = is_dark ? exp_la : ((exp_la > exp_lb) ? exp_la : exp_lb);
    it.dark = is_dark;
    it.len  = is_dark ? exp_la : exp_pre + (tmo ? TMO : d);
    sb_q.push_back(it);
    pushed++;
    chg = !is_dark;
    @(negedge clk) hit = 1'b1;
    @(negedge clk) hit = 1'b0;
    chk({"R2 start ", tag}, int'(tot), 1);
    pre = 1;
    if (is_dark) begin
      while (1) begin
        @(negedge clk);
        hit = repulse && pre == 2;
        if (!tot) break;
        pre++;
      end
      hit = 1'b0;
      chk({"R3 dark width ", tag}, pre, exp_la);
    end else begin
      while (1) begin
        @(negedge clk);
        hit = repulse && pre == 3;
        if (dchg_en) break;
        pre++;
      end
      hit = 1'b0;
      chk({"R4 pre-discharge ", tag}, pre, exp_pre);
      if (!tmo) begin
        repeat (d - 1) @(negedge clk);
        done = 1'b1;
      end
      do @(negedge clk); while (tot);
      done = 1'b0;
    end
    repeat (3) @(negedge clk);
    chg = 1'b0;
  endtask

  // monitor: compares each event report with the queue head
  int run = 0, post = 0;
  logic tot_q = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (post == 1) begin
        chk("R10 reset cycle 2", int'(rstb), 1);
        chk("R8 strobe single", int'(stb), 0);
        post = 2;
      end else if (post == 2) begin
        chk("R10 reset over", int'(rstb), 0);
        post = 0;
      end
      if (tot) run = tot_q ? run + 1 : 1;
      tot_q = tot;
      if (stb) begin
        item_t e;
        stb_seen++;
        post = 1;
        if (sb_q.size() == 0) begin
          chk("R8 unexpected strobe", 1, 0);
        end else begin
          e = sb_q.pop_front();
          chk("R8 class", int'(dark), int'(e.dark));
          chk("R8 length", int'(len_o), e.len);
          chk("R8 measured ToT", run, e.len);
          chk("R3/R5 rst_a", int'(rsta), int'(e.dark));
          chk("R5 rst_b", int'(rstb), 1);
          chk("R5 tot low", int'(tot), 0);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 tot", int'(tot), 0);
    chk("R1 resets", int'({rsta, rstb, dchg_en}), 0);
    chk("R1 err", int'(err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 stb", int'(stb), 0);
    chk("R1 cfg out", int'({thr_o, dchg_o}), 0);

    cfg(5, 10, 8'hA5, 9);
    run_event("dark", 1'b1, 0, 1'b0, 1'b0);
    run_event("valid", 1'b0, 7, 1'b0, 1'b0);
    run_event("valid repulse", 1'b0, 1, 1'b0, 1'b1);
    run_event("dark repulse", 1'b1, 0, 1'b0, 1'b1);

    // R6: zero settings act as one step
    cfg(0, 0, 8'h10, 1);
    run_event("R6 zero dark", 1'b1, 0, 1'b0, 1'b0);
    run_event("R6 zero valid", 1'b0, 3, 1'b0, 1'b0);

    // window A longer than window B
    cfg(20, 3, 8'h3C, 4);
    run_event("A longer", 1'b0, 2, 1'b0, 1'b0);

    // R10: hit held high across the event end does not retrigger
    cfg(5, 10, 8'h22, 2);
    sb_q.push_back('{dark: 1'b1, len: exp_la});
    pushed++;
    chg = 1'b0;
    @(negedge clk) hit = 1'b1;
    @(negedge clk) hit = 1'b0;
    @(negedge clk) hit = 1'b1;
    do @(negedge clk); while (tot);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R10 no retrigger", int'(tot), 0);
    end
    hit = 1'b0;
    repeat (2) @(negedge clk);

    // R7: discharge-done never arrives
    run_event("R7 timeout", 1'b0, 0, 1'b1, 1'b0);
    chk("R7 err set", int'(err), 1);
    repeat (5) @(negedge clk);
    chk("R7 err sticky", int'(err), 1);
    cfg(5, 10, 8'h22, 2);
    chk("R7 err cleared", int'(err), 0);

    repeat (4) @(negedge clk);
    chk("R8 queue drained", sb_q.size(), 0);
    chk("R8 strobe count", stb_seen, pushed);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule